// File: doc/BRIEF.md
# Masked Vector Floating-Point Min/Max Reduction

This block reduces one vector operand to a single floating-point scalar. It uses either the maximum or the minimum operation. The surrounding pipeline presents the instruction word, the element width and the vector length together with a start strobe. In the same cycle it presents the scalar that seeds the accumulator, which is element 0 of the first source register. The block decodes the instruction and checks it for legality. If the reduction is a legal min/max, the pipeline then streams the second-source elements one per beat, each with its mask bit. The block folds each active element into the accumulator in index order.

After the last element has been consumed, a one-cycle done strobe returns the scalar for element 0 of the destination register, along with a write enable and the destination index. Only that one element is written; the rest of the destination stays with the register file untouched. The done strobe also carries a request to clear the restart index, an illegal flag, an unsupported flag and a sticky invalid-operation flag. Sum and widening-sum reductions are recognised but reported as unsupported, because no adder is present. The datapath handles 16-, 32- and 64-bit elements with one set of comparison logic.

Top module: `vfminmax_red`

## Requirements
- R1: An instruction is recognised only when bits [6:0] are 1010111, bits [14:12] are 001, and funct6 (bits [31:26]) is one of the six reduction codes listed in R2. Anything else ends with done and illegal set. vd is bits [11:7], vs1 is bits [19:15], vs2 is bits [24:20] and vm is bit 25. The vs1 and vs2 indices are shown combinationally on `src1_idx` and `src2_idx`.
- R2: funct6 000111 selects maximum and 000101 selects minimum. funct6 000011 and 000001 (ordered/unordered sum) and 110011 and 110001 (widening sums) end, when legal, one cycle after start with done and unsupported set and no result write.
- R3: `sew` encodes the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Width code 0 is illegal for all six reductions: done and illegal one cycle after start.
- R4: A widening sum needs a source width of at least 16 and a doubled width of at most 64. Width codes 0 and 3 are therefore illegal for it.
- R5: The accumulator is loaded at start from the low element-width bits of `seed`. If no element is active, the result equals the seed and the invalid flag stays clear.
- R6: With vm = 1 every element is active and `elem_mask` is ignored. With vm = 0 an element is active only when its `elem_mask` is 1. An inactive element leaves the accumulator unchanged.
- R7: Elements are accepted on beats with `elem_valid` high; idle beats are allowed between them. The done strobe, with `result_we` high, comes one cycle after the vl-th element is accepted. `result` holds the reduction in its low element-width bits and zeros above them, element bits above the width are ignored, and `result_idx` equals vd. Done is high for exactly one cycle.
- R8: For a legal min/max with vl = 0, done comes one cycle after start with `result_we` low and `vstart_clr` high.
- R9: When exactly one operand is NaN, the other operand is the result. When both are NaN, the result is the canonical quiet NaN: 0x7E00, 0x7FC00000 or 0x7FF8000000000000 for widths 16, 32 and 64.
- R10: Non-NaN operands are ordered numerically, with -0 below +0. Maximum returns the larger operand and minimum the smaller.
- R11: `fp_invalid` is cleared at start. It becomes set when either operand of a performed comparison is a signalling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0), and it is reported with done.
- R12: `vstart_clr` is asserted only together with done, and only when a legal min/max completes. It is never asserted with illegal or unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction (taken only when idle) |
| instr | input | 32 | Instruction word |
| sew | input | 2 | Element width code |
| vl | input | CNT_W | Vector length |
| seed | input | 64 | Element 0 of vs1 |
| elem_valid | input | 1 | An element of vs2 is presented |
| elem_data | input | 64 | vs2 element, low element-width bits |
| elem_mask | input | 1 | Mask bit of the presented element |
| busy | output | 1 | A reduction is in progress |
| src1_idx | output | 5 | vs1 index of the presented instruction |
| src2_idx | output | 5 | vs2 index of the presented instruction |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Completion was an illegal instruction |
| unsupported | output | 1 | Completion was a recognised sum reduction |
| result_we | output | 1 | Write result to element 0 of vd |
| result_idx | output | 5 | vd index |
| result | output | 64 | Reduction result |
| fp_invalid | output | 1 | Signalling NaN seen in a comparison |
| vstart_clr | output | 1 | Clear the restart index |

## Verification
The assertions assume three things about the inputs. `vl` never exceeds MAX_VL when start is taken. Elements arrive only while a min/max reduction is running. Exactly vl elements are delivered before the block waits for done. The bench keeps to this by starting only from idle, by streaming exactly vl beats (with occasional idle gaps) after a legal min/max start, and by sending no elements for illegal, unsupported or zero-length cases. Under these assumptions the assertions check the done timing, the illegal and zero-length outcomes, the hold on inactive elements, and that each fold step returns one of its operands or the canonical NaN.

// File: rtl/vred_pkg.sv
package vred_pkg;

  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  typedef enum logic [2:0] {
    RED_NONE,
    RED_MAX,
    RED_MIN,
    RED_OSUM,
    RED_USUM,
    RED_WOSUM,
    RED_WUSUM
  } red_kind_e;

  typedef struct packed {
    logic [63:0] val;
    logic        nv;
  } pick_t;

  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [2:0] F3_FVV  = 3'b001;

  // lanes of the active element width
  function automatic logic [63:0] lane_mask(sew_e s);
    case (s)
      SEW_16:  return 64'h0000_0000_0000_FFFF;
      SEW_32:  return 64'h0000_0000_FFFF_FFFF;
      SEW_64:  return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_0000_00FF;
    endcase
  endfunction

  function automatic logic [63:0] inf_pattern(sew_e s);
    case (s)
      SEW_16:  return 64'h0000_0000_0000_7C00;
      SEW_32:  return 64'h0000_0000_7F80_0000;
      SEW_64:  return 64'h7FF0_0000_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] qnan_pattern(sew_e s);
    case (s)
      SEW_16:  return 64'h0000_0000_0000_7E00;
      SEW_32:  return 64'h0000_0000_7FC0_0000;
      SEW_64:  return 64'h7FF8_0000_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] magnitude(logic [63:0] x, sew_e s);
    return x & (lane_mask(s) >> 1);
  endfunction

  function automatic logic sign_of(logic [63:0] x, sew_e s);
    return |(x & lane_mask(s) & ~(lane_mask(s) >> 1));
  endfunction

  // strict numeric less-than on non-NaN sign-magnitude values, -0 < +0
  function automatic logic below(logic [63:0] a, logic [63:0] b, sew_e s);
    logic sa, sb;
    sa = sign_of(a, s);
    sb = sign_of(b, s);
    if (sa != sb) return sa;
    if (!sa) return magnitude(a, s) < magnitude(b, s);
    return magnitude(a, s) > magnitude(b, s);
  endfunction

  // maximumNumber / minimumNumber with canonical NaN and invalid detection
  function automatic pick_t fp_pick(logic [63:0] a, logic [63:0] b, sew_e s,
                                    logic take_max);
    pick_t r;
    logic [63:0] ma, mb;
    logic na, nb, lt;
    ma = magnitude(a, s);
    mb = magnitude(b, s);
    na = ma > inf_pattern(s);
    nb = mb > inf_pattern(s);
    r.nv = (na && ma < qnan_pattern(s)) || (nb && mb < qnan_pattern(s));
    lt = below(a, b, s);
    if (na && nb)    r.val = qnan_pattern(s);
    else if (na)     r.val = b;
    else if (nb)     r.val = a;
    else if (take_max) r.val = lt ? b : a;
    else             r.val = lt ? a : b;
    return r;
  endfunction

endpackage

// File: rtl/vred_decode.sv
module vred_decode
  import vred_pkg::*;
(
  input  logic [31:0] instr,
  input  sew_e        sew,
  output red_kind_e   kind,
  output logic        vm,
  output logic        take_max,
  output logic        illegal,
  output logic        unsup,
  output logic [4:0]  vd,
  output logic [4:0]  vs1,
  output logic [4:0]  vs2
);

  logic       frame_ok;
  logic       wide;
  logic [5:0] f6;

  assign f6       = instr[31:26];
  assign vm       = instr[25];
  assign vs2      = instr[24:20];
  assign vs1      = instr[19:15];
  assign vd       = instr[11:7];
  assign frame_ok = (instr[6:0] == OPC_VEC) && (instr[14:12] == F3_FVV);

  always_comb begin
    case (f6)
      6'b000111: kind = RED_MAX;
      6'b000101: kind = RED_MIN;
      6'b000011: kind = RED_OSUM;
      6'b000001: kind = RED_USUM;
      6'b110011: kind = RED_WOSUM;
      6'b110001: kind = RED_WUSUM;
      default:   kind = RED_NONE;
    endcase
    if (!frame_ok) kind = RED_NONE;
  end

  assign wide     = (kind == RED_WOSUM) || (kind == RED_WUSUM);
  assign take_max = (kind == RED_MAX);
  assign illegal  = (kind == RED_NONE) || (sew == SEW_8) || (wide && sew == SEW_64);
  assign unsup    = !illegal && (kind != RED_MAX) && (kind != RED_MIN);

endmodule

// File: rtl/vred_fold.sv
module vred_fold
  import vred_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [63:0] seed,
  input  logic        step,
  input  logic        active,
  input  logic [63:0] elem,
  input  sew_e        sew,
  input  logic        take_max,
  output logic [63:0] acc,
  output logic        nv
);

  logic [63:0] elem_lane;
  pick_t       pick;
  logic        fold_now;

  assign elem_lane = elem & lane_mask(sew);
  assign pick      = fp_pick(acc, elem_lane, sew, take_max);
  assign fold_now  = step && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      nv  <= 1'b0;
    end else if (load) begin
      acc <= seed & lane_mask(sew);
      nv  <= 1'b0;
    end else if (fold_now) begin
      acc <= pick.val;
      nv  <= nv | pick.nv;
    end
  end

  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !active && !load) |=> $stable(acc)); // R6

  AST_PICK_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_now && !load) |=> (acc == $past(acc) || acc == $past(elem_lane) ||
                             acc == qnan_pattern($past(sew)))); // R9

endmodule

// File: rtl/vfminmax_red.sv
module vfminmax_red
  import vred_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      instr,
  input  logic [1:0]       sew,
  input  logic [CNT_W-1:0] vl,
  input  logic [63:0]      seed,
  input  logic             elem_valid,
  input  logic [63:0]      elem_data,
  input  logic             elem_mask,
  output logic             busy,
  output logic [4:0]       src1_idx,
  output logic [4:0]       src2_idx,
  output logic             done,
  output logic             illegal,
  output logic             unsupported,
  output logic             result_we,
  output logic [4:0]       result_idx,
  output logic [63:0]      result,
  output logic             fp_invalid,
  output logic             vstart_clr
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e           state;
  sew_e             sew_in, sew_q;
  red_kind_e        dec_kind;
  logic             dec_vm, dec_max, dec_illegal, dec_unsup;
  logic [4:0]       dec_vd;
  logic             vm_q, max_q, ill_q, uns_q, we_q, ok_q;
  logic [CNT_W-1:0] vl_q, cnt;
  logic             start_acc, beat, elem_active, last_beat;

  assign sew_in      = sew_e'(sew);
  assign start_acc   = start && (state == ST_IDLE);
  assign beat        = elem_valid && (state == ST_RUN);
  assign elem_active = vm_q || elem_mask;
  assign last_beat   = beat && (cnt == vl_q - 1'b1);

  vred_decode u_dec (
    .instr    (instr),
    .sew      (sew_in),
    .kind     (dec_kind),
    .vm       (dec_vm),
    .take_max (dec_max),
    .illegal  (dec_illegal),
    .unsup    (dec_unsup),
    .vd       (dec_vd),
    .vs1      (src1_idx),
    .vs2      (src2_idx)
  );

  vred_fold u_fold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_acc),
    .seed     (seed),
    .step     (beat),
    .active   (elem_active),
    .elem     (elem_data),
    .sew      (start_acc ? sew_in : sew_q),
    .take_max (max_q),
    .acc      (result),
    .nv       (fp_invalid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sew_q      <= SEW_16;
      vm_q       <= 1'b1;
      max_q      <= 1'b0;
      ill_q      <= 1'b0;
      uns_q      <= 1'b0;
      we_q       <= 1'b0;
      ok_q       <= 1'b0;
      vl_q       <= '0;
      cnt        <= '0;
      result_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          sew_q      <= sew_in;
          vm_q       <= dec_vm;
          max_q      <= dec_max;
          ill_q      <= dec_illegal;
          uns_q      <= dec_unsup;
          vl_q       <= vl;
          cnt        <= '0;
          result_idx <= dec_vd;
          ok_q       <= !dec_illegal && !dec_unsup;
          we_q       <= !dec_illegal && !dec_unsup && (vl != '0);
          if (dec_illegal || dec_unsup || vl == '0) state <= ST_FIN;
          else                                       state <= ST_RUN;
        end
        ST_RUN: if (beat) begin
          cnt <= cnt + 1'b1;
          if (last_beat) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign illegal     = done && ill_q;
  assign unsupported = done && uns_q;
  assign result_we   = done && we_q;
  assign vstart_clr  = done && ok_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> (vl <= CNT_W'(MAX_VL))); // R7

  AST_SEW8_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && sew_in == SEW_8) |=> (done && illegal)); // R3

  AST_WIDE64_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && sew_in == SEW_64 && (dec_kind == RED_WOSUM || dec_kind == RED_WUSUM))
      |=> (done && illegal)); // R4

  AST_VL0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !dec_illegal && !dec_unsup && vl == '0)
      |=> (done && vstart_clr && !result_we)); // R8

  AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> !result_we); // R2

  AST_VSTART_OK: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> (!illegal && !unsupported)); // R12

endmodule

// File: tb/tb_vfminmax_red.sv
module tb_vfminmax_red;

  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 64;
  localparam int VLW  = $clog2(MAXV + 1);

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] instr = '0;
  logic [1:0] sew = 2'd1;
  logic [VLW-1:0] vl = '0;
  logic [63:0] seed = '0, elem_data = '0;
  logic elem_valid = 0, elem_mask = 0;
  logic busy, done, illegal, unsupported, result_we, fp_invalid, vstart_clr;
  logic [4:0] src1_idx, src2_idx, result_idx;
  logic [63:0] result;

  vfminmax_red #(.MAX_VL(MAXV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sew(sew), .vl(vl),
    .seed(seed), .elem_valid(elem_valid), .elem_data(elem_data), .elem_mask(elem_mask),
    .busy(busy), .src1_idx(src1_idx), .src2_idx(src2_idx), .done(done),
    .illegal(illegal), .unsupported(unsupported), .result_we(result_we),
    .result_idx(result_idx), .result(result), .fp_invalid(fp_invalid),
    .vstart_clr(vstart_clr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [63:0] ev [0:MAXV-1];
  logic        em [0:MAXV-1];
  logic r_done, r_ill, r_uns, r_we, r_vclr, r_nv;
  logic [63:0] r_res;
  logic [4:0]  r_idx;
  bit gaps = 0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected end)");
    report();
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // element format helpers
  function automatic int fw(int s);  return s == 1 ? 16 : s == 2 ? 32 : 64; endfunction
  function automatic int fm(int s);  return s == 1 ? 10 : s == 2 ? 23 : 52; endfunction
  function automatic logic [63:0] wmask(int s);
    return fw(s) == 64 ? '1 : (64'd1 << fw(s)) - 64'd1;
  endfunction
  function automatic logic [63:0] expfield(int s);
    return (wmask(s) >> 1) & ~((64'd1 << fm(s)) - 64'd1);
  endfunction
  function automatic bit is_nan(logic [63:0] x, int s);
    return ((x & expfield(s)) == expfield(s)) && ((x & ((64'd1 << fm(s)) - 64'd1)) != 0);
  endfunction
  function automatic bit is_snan(logic [63:0] x, int s);
    return is_nan(x, s) && !x[fm(s)-1];
  endfunction
  function automatic logic [63:0] canon(int s);
    return expfield(s) | (64'd1 << (fm(s) - 1));
  endfunction
  function automatic logic [63:0] okey(logic [63:0] x, int s);
    return x[fw(s)-1] ? (~x & wmask(s)) : (x | (64'd1 << (fw(s) - 1)));
  endfunction

  function automatic logic [63:0] ref_pick(logic [63:0] a, logic [63:0] b, int s, bit mx, output bit nv);
    nv = is_snan(a, s) || is_snan(b, s);
    if (is_nan(a, s) && is_nan(b, s)) return canon(s);
    if (is_nan(a, s)) return b;
    if (is_nan(b, s)) return a;
    if (mx) return (okey(a, s) >= okey(b, s)) ? a : b;
    return (okey(a, s) <= okey(b, s)) ? a : b;
  endfunction

  // special value pool: k[3] sign, k[2:0] kind
  function automatic logic [63:0] sp(int k, int s);
    logic [63:0] one, v;
    one = ((64'd1 << (fw(s) - fm(s) - 2)) - 64'd1) << fm(s);
    case (k % 8)
      0: v = 64'd0;
      1: v = 64'd1;
      2: v = one;
      3: v = one | (64'd1 << (fm(s) - 1));
      4: v = expfield(s) - 64'd1;
      5: v = expfield(s);
      6: v = canon(s);
      default: v = expfield(s) | 64'd1;
    endcase
    if (k >= 8) v = v | (64'd1 << (fw(s) - 1));
    return v;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] f6, logic vmb, logic [4:0] vs2, logic [4:0] vs1, logic [4:0] vd);
    return {f6, vmb, vs2, vs1, 3'b001, vd, 7'b1010111};
  endfunction

  task automatic run_red(input logic [31:0] ins, input logic [1:0] s, input int n, input logic [63:0] sd);
    @(negedge clk);
    start = 1; instr = ins; sew = s; vl = VLW'(n); seed = sd;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        elem_valid = 0;
        @(negedge clk);
      end
      elem_valid = 1; elem_data = ev[i]; elem_mask = em[i];
      @(negedge clk);
    end
    elem_valid = 0;
    r_done = done; r_ill = illegal; r_uns = unsupported; r_we = result_we;
    r_vclr = vstart_clr; r_res = result; r_nv = fp_invalid; r_idx = result_idx;
    @(negedge clk);
  endtask

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !result_we && !vstart_clr, "R7 reset idle", {60'd0, busy, done, result_we, vstart_clr}, 64'd0);
    rst_n = 1;

    // R1 source index fields
    @(negedge clk);
    instr = mk(6'b000111, 1'b1, 5'd19, 5'd6, 5'd2);
    #1;
    chk(src1_idx == 5'd6 && src2_idx == 5'd19, "R1 src indices", {54'd0, src1_idx, src2_idx}, {54'd0, 5'd6, 5'd19});

    // decode sweep, vl = 0
    for (int f = 0; f < 64; f++) begin
      for (int s = 0; s < 4; s++) begin
        bit mm, su, ws, ei, eu, ec;
        string tag;
        mm = (f == 6'b000111) || (f == 6'b000101);
        su = (f == 6'b000011) || (f == 6'b000001);
        ws = (f == 6'b110011) || (f == 6'b110001);
        ei = !(mm || su || ws) || s == 0 || (ws && s == 3);
        eu = !ei && !mm;
        ec = !ei && mm;
        tag = !(mm || su || ws) ? "R1 unknown funct6" : s == 0 ? "R3 width 8" :
              (ws && s == 3) ? "R4 widening width" : mm ? "R8 vl zero" : "R2 sum unsupported";
        run_red(mk(6'(f), 1'b1, 5'd3, 5'd4, 5'd5), 2'(s), 0, 64'h0);
        chk({r_done, r_ill, r_uns, r_we, r_vclr} == {1'b1, ei, eu, 1'b0, ec}, tag,
            {59'd0, r_done, r_ill, r_uns, r_we, r_vclr}, {59'd0, 1'b1, ei, eu, 1'b0, ec});
      end
    end
    begin
      logic [31:0] w;
      w = mk(6'b000111, 1'b1, 5'd1, 5'd1, 5'd1);
      run_red({w[31:7], 7'b1010110}, 2'd2, 0, 64'h0);
      chk(r_done && r_ill && !r_vclr, "R1 wrong opcode", {61'd0, r_done, r_ill, r_vclr}, 64'h6);
      run_red({w[31:15], 3'b010, w[11:0]}, 2'd2, 0, 64'h0);
      chk(r_done && r_ill && !r_vclr, "R1 wrong funct3", {61'd0, r_done, r_ill, r_vclr}, 64'h6);
      run_red(mk(6'b000101, 1'b1, 5'd1, 5'd1, 5'd1), 2'd0, 0, 64'h0);
      chk(!r_vclr && !r_we, "R12 no clear on illegal", {62'd0, r_vclr, r_we}, 64'd0);
    end

    // exhaustive special-value pairs, vl = 1, vm = 1 with mask 0 (mask ignored)
    for (int s = 1; s < 4; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          for (int op = 0; op < 2; op++) begin
            logic [63:0] exp_v;
            bit exp_nv;
            ev[0] = sp(b, s); em[0] = 0;
            exp_v = ref_pick(sp(a, s), sp(b, s), s, op == 0, exp_nv);
            run_red(mk(op == 0 ? 6'b000111 : 6'b000101, 1'b1, 5'd8, 5'd9, 5'd10), 2'(s), 1, sp(a, s));
            chk(r_done && r_we && r_res == exp_v,
                (is_nan(sp(a, s), s) || is_nan(sp(b, s), s)) ? "R9 nan pair" : "R10 ordered pair",
                r_res, exp_v);
            chk(r_nv == exp_nv, "R11 invalid flag", {63'd0, r_nv}, {63'd0, exp_nv});
          end
        end
      end
    end

    // seed only: all masked off
    for (int s = 1; s < 4; s++) begin
      for (int i = 0; i < 3; i++) begin ev[i] = sp(2, s); em[i] = 0; end
      run_red(mk(6'b000111, 1'b0, 5'd1, 5'd2, 5'd3), 2'(s), 3, sp(15, s) | ~wmask(s));
      chk(r_res == sp(15, s) && !r_nv && r_we, "R5 seed kept", r_res, sp(15, s));
    end

    // random vectors with masks, gaps and junk upper bits
    gaps = 1;
    for (int t = 0; t < 150; t++) begin
      int s, n;
      bit mx, vmb, nv_acc, nv1;
      logic [63:0] acc, sd, lane;
      logic [4:0] vd;
      s = 1 + ($urandom % 3);
      n = 1 + ($urandom % 24);
      if (t % 10 == 0) n = MAXV;
      mx = $urandom % 2;
      vmb = $urandom % 2;
      vd = 5'($urandom);
      sd = ($urandom % 2) ? sp($urandom % 16, s) : {$urandom, $urandom};
      sd = sd | (~wmask(s) & {$urandom, $urandom});
      for (int i = 0; i < n; i++) begin
        ev[i] = ($urandom % 3 == 0) ? sp($urandom % 16, s) : {$urandom, $urandom};
        ev[i] = ev[i] | (~wmask(s) & {$urandom, $urandom});
        em[i] = $urandom % 2;
      end
      acc = sd & wmask(s); nv_acc = 0;
      for (int i = 0; i < n; i++) begin
        if (vmb || em[i]) begin
          lane = ev[i] & wmask(s);
          acc = ref_pick(acc, lane, s, mx, nv1);
          nv_acc = nv_acc | nv1;
        end
      end
      run_red(mk(mx ? 6'b000111 : 6'b000101, vmb, 5'd7, 5'd8, vd), 2'(s), n, sd);
      chk(r_done && r_we && r_vclr && r_res == acc, vmb ? "R6 vm=1 fold" : "R6 masked fold", r_res, acc);
      chk(r_idx == vd && r_nv == nv_acc, "R7 index and flag", {58'd0, r_idx, r_nv}, {58'd0, vd, nv_acc});
    end

    report();
  end

endmodule